// File: doc/BRIEF.md
# Wake-Frame Pattern Detector

This block watches the bytes of a received Ethernet frame as they arrive and recognises a remote wake frame meant for this station. Bytes arrive one per cycle while `rx_valid` is high. `rx_sof` marks the first byte of a frame and `rx_eof` marks the last. `rx_err` is sampled together with the last byte and carries the frame-check verdict of the receive path upstream.

A frame qualifies when two conditions hold. First, its destination address must be the station's own 48-bit node ID or any group address. Second, somewhere after the two address fields its payload must contain a run of six 0xFF bytes followed at once by sixteen back-to-back copies of the node ID. When a qualifying frame ends cleanly and both enables are high, the block raises a single-cycle wake pulse. That pulse is intended for the power-management logic around it.

The search runs as a streaming matcher with a few counters. It resynchronises after partial matches and after runs of 0xFF of any length, so the pattern may start at any byte offset from byte 12 onward.

Top module: `wol_magic_detect`

## Requirements
- R1: Address byte k of a frame (k = 0..5, byte 0 first on the wire) is compared with `node_id[47-8k -: 8]`. A frame whose six destination bytes all match this is accepted as addressed to the station.
- R2: A destination whose byte 0 has bit 0 set is a group address and is also accepted; all-ones broadcast is one such address. A destination that neither matches the node ID nor has that bit set makes the frame unable to wake, even when its pattern is perfect.
- R3: The wake pattern is exactly six 0xFF bytes followed with no gap by sixteen copies of the node ID, each copy sent in R1 byte order. Only bytes at index 12 or later are searched. A pattern that starts inside bytes 0..11, or that has fewer sync bytes or fewer copies, does not count.
- R4: A run of more than six 0xFF bytes keeps the matcher synchronised, so the ID copies may follow any run of six or more.
- R5: A byte that breaks the ID copies restarts the search. If that byte is 0xFF, it counts as the first byte of a new sync run.
- R6: `wake_pulse` is high for exactly one cycle, the cycle right after the clock edge that takes the frame's last byte. It is raised only if the pattern was found, the destination was accepted and `rx_err` was low on that byte.
- R7: No pulse is issued unless `en_magic` and `en_pm` are both high when the last byte is taken.
- R8: Every start of frame clears all match and address state, so a pattern split across two frames never wakes.
- R9: Cycles with `rx_valid` low are ignored whatever the data lines carry; a frame may be delivered with idle cycles between its bytes.
- R10: While reset is held and right after it, `wake_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_magic | input | 1 | Wake-pattern detection enable |
| en_pm | input | 1 | Power-management enable |
| node_id | input | 48 | Station node ID, byte 0 in bits 47:40 |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_err | input | 1 | Frame is bad; valid with the last byte |
| wake_pulse | output | 1 | One-cycle wake event |

## Verification
A wrong matcher state has no effect at the ports until the frame ends. A missed resync, a miscounted sync run or a copy counter that stops one short all show up as a missing or spurious `wake_pulse` one cycle after the last byte, and never earlier. The stimulus therefore places the pattern at several offsets: after long 0xFF runs, after broken copies (including one broken by a 0xFF byte), inside the header, and split across two frames. Each frame's end is then the point where the result is checked. Address-check and enable faults are caught the same way, by frames whose pattern is perfect but whose destination, error flag or enables should block the pulse.

// File: rtl/wol_pkg.sv
`timescale 1ns/1ps
package wol_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        MS_HUNT = 2'd0,
        MS_SYNC = 2'd1,
        MS_COPY = 2'd2
    } match_state_e;
endpackage

// File: rtl/wol_dst_check.sv
`timescale 1ns/1ps
module wol_dst_check
    import wol_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HDR_BYTES  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_BYTES*BYTE_W-1:0] node_id,
    input  logic                        rx_valid,
    input  logic [BYTE_W-1:0]           rx_data,
    input  logic                        rx_sof,
    input  logic                        rx_eof,
    output logic                        frame_byte,
    output logic                        payload_byte,
    output logic                        dst_ok
);
    localparam int POS_W = $clog2(HDR_BYTES + 1);
    localparam logic [POS_W-1:0] POS_ADDR_END = POS_W'(ADDR_BYTES);
    localparam logic [POS_W-1:0] POS_HDR_END  = POS_W'(HDR_BYTES);

    typedef struct packed {
        logic             in_frame;
        logic [POS_W-1:0] pos;
        logic             grp;
        logic             eq;
    } hdr_state_t;

    hdr_state_t s_d, s_q;
    logic [BYTE_W-1:0] exp_byte;

    // node ID byte expected at the current address position
    always_comb begin
        exp_byte = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (s_q.pos == POS_W'(i)) begin
                exp_byte = node_id[(ADDR_BYTES-1-i)*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        s_d = s_q;
        frame_byte   = rx_valid && (rx_sof || s_q.in_frame);
        payload_byte = rx_valid && !rx_sof && s_q.in_frame && (s_q.pos == POS_HDR_END);
        dst_ok       = !(rx_valid && rx_sof) && (s_q.pos >= POS_ADDR_END) && (s_q.grp || s_q.eq);

        if (rx_valid) begin
            if (rx_sof) begin
                s_d.in_frame = !rx_eof;
                s_d.pos      = POS_W'(1);
                s_d.grp      = rx_data[0];
                s_d.eq       = (rx_data == node_id[ADDR_BYTES*BYTE_W-1 -: BYTE_W]);
            end else if (s_q.in_frame) begin
                if (s_q.pos < POS_ADDR_END) begin
                    s_d.eq = s_q.eq && (rx_data == exp_byte);
                end
                if (s_q.pos < POS_HDR_END) begin
                    s_d.pos = s_q.pos + 1'b1;
                end
                if (rx_eof) begin
                    s_d.in_frame = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wol_pattern_match.sv
`timescale 1ns/1ps
module wol_pattern_match
    import wol_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int SYNC_LEN   = 6,
    parameter int COPIES     = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_BYTES*BYTE_W-1:0] node_id,
    input  logic                        clear,
    input  logic                        byte_en,
    input  logic [BYTE_W-1:0]           rx_data,
    output logic                        found,
    output logic                        found_q
);
    localparam int SYNC_W = $clog2(SYNC_LEN + 1);
    localparam int BIDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int COPY_W = (COPIES > 1) ? $clog2(COPIES) : 1;
    localparam logic [SYNC_W-1:0] SYNC_LAST = SYNC_W'(SYNC_LEN - 1);
    localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(ADDR_BYTES - 1);
    localparam logic [COPY_W-1:0] COPY_LAST = COPY_W'(COPIES - 1);

    typedef struct packed {
        match_state_e      st;
        logic [SYNC_W-1:0] ff_cnt;
        logic [BIDX_W-1:0] bidx;
        logic [COPY_W-1:0] cidx;
        logic              found;
    } match_state_t;

    match_state_t s_d, s_q;
    logic [BYTE_W-1:0] exp_byte;
    logic is_ff, id_ok, adv, hit;

    // node ID byte expected at the current position inside a copy
    always_comb begin
        exp_byte = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (s_q.bidx == BIDX_W'(i)) begin
                exp_byte = node_id[(ADDR_BYTES-1-i)*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        s_d   = s_q;
        adv   = 1'b0;
        hit   = 1'b0;
        is_ff = (rx_data == SYNC_BYTE);
        id_ok = (rx_data == exp_byte);

        if (clear) begin
            s_d.st     = MS_HUNT;
            s_d.ff_cnt = '0;
            s_d.bidx   = '0;
            s_d.cidx   = '0;
            s_d.found  = 1'b0;
        end else if (byte_en) begin
            unique case (s_q.st)
                MS_HUNT: begin
                    if (is_ff) begin
                        if (s_q.ff_cnt == SYNC_LAST) begin
                            s_d.st     = MS_SYNC;
                            s_d.ff_cnt = '0;
                            s_d.bidx   = '0;
                            s_d.cidx   = '0;
                        end else begin
                            s_d.ff_cnt = s_q.ff_cnt + 1'b1;
                        end
                    end else begin
                        s_d.ff_cnt = '0;
                    end
                end
                MS_SYNC: begin
                    if (id_ok) begin
                        s_d.st = MS_COPY;
                        adv    = 1'b1;
                    end else if (!is_ff) begin
                        s_d.st = MS_HUNT;
                    end
                end
                MS_COPY: begin
                    if (id_ok) begin
                        adv = 1'b1;
                    end else begin
                        s_d.st     = MS_HUNT;
                        s_d.ff_cnt = is_ff ? SYNC_W'(1) : '0;
                        s_d.bidx   = '0;
                        s_d.cidx   = '0;
                    end
                end
                default: s_d.st = MS_HUNT;
            endcase

            if (adv) begin
                if (s_q.bidx == BIDX_LAST) begin
                    s_d.bidx = '0;
                    if (s_q.cidx == COPY_LAST) begin
                        hit       = 1'b1;
                        s_d.found = 1'b1;
                        s_d.st    = MS_HUNT;
                        s_d.cidx  = '0;
                    end else begin
                        s_d.cidx = s_q.cidx + 1'b1;
                    end
                end else begin
                    s_d.bidx = s_q.bidx + 1'b1;
                end
            end
        end

        found   = !clear && (s_q.found || hit);
        found_q = s_q.found;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wol_magic_detect.sv
`timescale 1ns/1ps
module wol_magic_detect
    import wol_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int SYNC_LEN   = 6,
    parameter int COPIES     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_magic,
    input  logic        en_pm,
    input  logic [47:0] node_id,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_err,
    output logic        wake_pulse
);
    localparam int HDR_BYTES = 2 * ADDR_BYTES;

    typedef struct packed {
        logic wake;
    } top_state_t;

    top_state_t s_d, s_q;
    logic frame_byte, payload_byte, dst_ok;
    logic pat_found, pat_found_q;
    logic sof_byte;

    assign sof_byte = rx_valid && rx_sof;

    wol_dst_check #(
        .ADDR_BYTES (ADDR_BYTES),
        .HDR_BYTES  (HDR_BYTES)
    ) u_dst (
        .clk          (clk),
        .rst_n        (rst_n),
        .node_id      (node_id),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .frame_byte   (frame_byte),
        .payload_byte (payload_byte),
        .dst_ok       (dst_ok)
    );

    wol_pattern_match #(
        .ADDR_BYTES (ADDR_BYTES),
        .SYNC_LEN   (SYNC_LEN),
        .COPIES     (COPIES)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .node_id  (node_id),
        .clear    (sof_byte),
        .byte_en  (payload_byte),
        .rx_data  (rx_data),
        .found    (pat_found),
        .found_q  (pat_found_q)
    );

    always_comb begin
        s_d.wake = frame_byte && rx_eof && !rx_err && en_magic && en_pm
                   && dst_ok && pat_found;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wake_pulse = s_q.wake;
endmodule

// File: rtl/wol_magic_chk.sv
`timescale 1ns/1ps
module wol_magic_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_sof,
    input logic rx_eof,
    input logic rx_err,
    input logic en_magic,
    input logic en_pm,
    input logic dst_ok,
    input logic payload_byte,
    input logic pat_found_q,
    input logic wake_pulse
);
    p_wake_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    p_wake_clean_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(rx_valid && rx_eof && !rx_err));

    p_wake_enables_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(en_magic && en_pm));

    p_wake_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(dst_ok));

    p_sof_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_valid && rx_sof) |-> !pat_found_q);

    p_found_from_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pat_found_q) |-> $past(payload_byte));
endmodule

bind wol_magic_detect wol_magic_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_sof       (rx_sof),
    .rx_eof       (rx_eof),
    .rx_err       (rx_err),
    .en_magic     (en_magic),
    .en_pm        (en_pm),
    .dst_ok       (dst_ok),
    .payload_byte (payload_byte),
    .pat_found_q  (pat_found_q),
    .wake_pulse   (wake_pulse)
);

// File: tb/wol_magic_detect_tb.sv
`timescale 1ns/1ps
module wol_magic_detect_tb_top;
    localparam logic [47:0] NODE_ID = 48'h021A3C4D5E6F;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, en_magic, en_pm;
    logic       rx_valid, rx_sof, rx_eof, rx_err;
    logic [7:0] rx_data;
    logic       wake_pulse;

    wol_magic_detect dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_magic   (en_magic),
        .en_pm      (en_pm),
        .node_id    (NODE_ID),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .rx_err     (rx_err),
        .wake_pulse (wake_pulse)
    );

    logic [7:0] frm[$];
    bit         exp_q[$];
    string      tag_q[$];
    int         vectors = 0;
    int         errors  = 0;
    bit         mon_on  = 0;

    function automatic logic [7:0] idb(int k);
        return NODE_ID[(5-k)*8 +: 8];
    endfunction

    task automatic put_addr(logic [47:0] a);
        for (int k = 0; k < 6; k++) frm.push_back(a[(5-k)*8 +: 8]);
    endtask

    task automatic put_hdr(logic [47:0] dst);
        put_addr(dst);
        put_addr(48'h0A0B0C0D0E10);
    endtask

    task automatic put_fill(logic [7:0] b, int n);
        for (int k = 0; k < n; k++) frm.push_back(b);
    endtask

    task automatic put_copies(int n);
        for (int c = 0; c < n; c++)
            for (int k = 0; k < 6; k++) frm.push_back(idb(k));
    endtask

    // expectation straight from the requirements
    function automatic bit ref_expect(bit err, bit em, bit ep);
        bit eq, dst, found, ok;
        eq = 1'b1;
        for (int k = 0; k < 6; k++) if (frm[k] != idb(k)) eq = 1'b0;
        dst = frm[0][0] || eq;
        found = 1'b0;
        for (int p = 12; p + 102 <= frm.size(); p++) begin
            ok = 1'b1;
            for (int j = 0; j < 6; j++) if (frm[p+j] != 8'hFF) ok = 1'b0;
            for (int j = 0; j < 96; j++) if (frm[p+6+j] != idb(j % 6)) ok = 1'b0;
            if (ok) found = 1'b1;
        end
        return dst && found && !err && em && ep;
    endfunction

    task automatic send(string tag, bit err, bit gaps);
        int last;
        exp_q.push_back(ref_expect(err, en_magic, en_pm));
        tag_q.push_back(tag);
        last = frm.size() - 1;
        for (int i = 0; i <= last; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = frm[i];
            rx_sof   = (i == 0);
            rx_eof   = (i == last);
            rx_err   = (i == last) ? err : 1'b0;
            if (gaps && (i % 5 == 2) && i != last) begin
                @(negedge clk);
                rx_valid = 1'b0;
                rx_data  = 8'hFF;
                rx_sof   = 1'b0;
                rx_eof   = 1'b0;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        rx_eof   = 1'b0;
        rx_err   = 1'b0;
        rx_data  = 8'h00;
        repeat (3) @(negedge clk);
        frm.delete();
    endtask

    task automatic std_frame();
        put_hdr(NODE_ID);
        put_fill(8'h5A, 2);
        put_fill(8'hFF, 6);
        put_copies(16);
        put_fill(8'h77, 3);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    // scoreboard monitor: compares at every clock edge after reset
    initial begin
        bit eof_s, e;
        string t;
        forever begin
            @(posedge clk);
            eof_s = rx_valid && rx_eof;
            #1;
            if (mon_on) begin
                if (eof_s) begin
                    vectors++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R6 no expectation queued: wake_pulse=%0b expected=none", wake_pulse);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if (wake_pulse !== e) begin
                            errors++;
                            $display("FAIL %s: wake_pulse=%0b expected=%0b", t, wake_pulse, e);
                        end
                    end
                end else if (wake_pulse !== 1'b0) begin
                    vectors++;
                    errors++;
                    $display("FAIL R6 pulse outside end-of-frame slot: wake_pulse=%0b expected=0", wake_pulse);
                end
            end
        end
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL R6 watchdog expired: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; en_magic = 1'b1; en_pm = 1'b1;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0; rx_data = 8'h00;
        repeat (4) @(negedge clk);
        vectors++;
        if (wake_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R10 during reset: wake_pulse=%0b expected=0", wake_pulse);
        end
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (wake_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R10 after reset: wake_pulse=%0b expected=0", wake_pulse);
        end
        mon_on = 1'b1;

        put_hdr(NODE_ID); put_fill(8'hFF, 6); put_copies(16);
        send("R1 R3 unicast, pattern at byte 12 ending on last byte", 0, 0);

        put_hdr(48'hFFFFFFFFFFFF); put_fill(8'h33, 5); put_fill(8'hFF, 6); put_copies(16); put_fill(8'h44, 4);
        send("R2 broadcast destination", 0, 0);

        put_hdr(48'h01005E000001); put_fill(8'hFF, 6); put_copies(16); put_fill(8'h44, 1);
        send("R2 group destination", 0, 0);

        put_hdr(48'h021A3C4D5E70); put_fill(8'hFF, 6); put_copies(16); put_fill(8'h44, 1);
        send("R1 R2 foreign unicast destination", 0, 0);

        put_hdr(NODE_ID); put_fill(8'h20, 3); put_fill(8'hFF, 13); put_copies(16); put_fill(8'h01, 2);
        send("R4 long sync run", 0, 0);

        put_hdr(NODE_ID); put_fill(8'hFF, 6); put_copies(3); put_fill(8'h00, 1);
        put_fill(8'hFF, 6); put_copies(16); put_fill(8'h01, 2);
        send("R5 partial match then full pattern", 0, 0);

        put_hdr(NODE_ID); put_fill(8'hFF, 6); put_copies(1); frm.push_back(idb(0)); frm.push_back(idb(1));
        put_fill(8'hFF, 1); put_fill(8'hFF, 5); put_copies(16); put_fill(8'h01, 1);
        send("R5 copy broken by 0xFF starts new sync", 0, 0);

        put_hdr(NODE_ID); put_fill(8'hFF, 6); put_copies(15); put_fill(8'h00, 4);
        send("R3 fifteen copies only", 0, 0);

        put_hdr(NODE_ID); put_fill(8'hFF, 5); put_copies(16); put_fill(8'h00, 2);
        send("R3 five sync bytes only", 0, 0);

        put_addr(48'hFFFFFFFFFFFF); put_copies(16); put_fill(8'h55, 4);
        send("R3 pattern starting inside header", 0, 0);

        std_frame();
        send("R6 error flag blocks wake", 1, 0);

        en_magic = 1'b0;
        std_frame();
        send("R7 pattern enable low", 0, 0);
        en_magic = 1'b1; en_pm = 1'b0;
        std_frame();
        send("R7 power enable low", 0, 0);
        en_pm = 1'b1;

        put_hdr(NODE_ID); put_fill(8'hFF, 6); put_copies(8);
        send("R8 first half of split pattern", 0, 0);
        put_hdr(NODE_ID); put_copies(8); put_fill(8'h01, 2);
        send("R8 second half of split pattern", 0, 0);

        std_frame();
        send("R9 idle cycles with 0xFF on data lines", 0, 1);

        std_frame();
        send("R6 clean frame after others", 0, 0);

        repeat (5) @(negedge clk);
        vectors++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 unchecked frames: left=%0d expected=0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule